// File: doc/BRIEF.md
# Byte-Exchange SPI Master with Register Access

This peripheral drives a four-wire SPI bus as master and moves one 8-bit frame in each direction per transfer. Software reaches it through a small 32-bit register bus. It chooses a bit rate and one of the four clock modes, and it drives the chip-select line by writing a register bit. To move a byte, software loads the transmit register. While that byte leaves on MOSI, most significant bit first, a byte is gathered from MISO. When the frame ends, the gathered byte sits in the receive register and a status flag reports that it is there.

The bit clock comes from the peripheral clock in two stages. A coarse stage divides by a fixed low or high factor, chosen by control bit 5. A fine stage divides by an even number, 2*(n+1), with n taken from control bits [4:0]. A status busy bit tells software when the next byte may be written. Writes that arrive while a frame is in flight are dropped in a defined way.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sck is 0 and spi_mosi is 0. The control register (0x00), status register (0x04) and receive register (0x10) read 0, and the system register (0x08) reads 0x40.
- R2: While a frame runs, each SCK half period lasts P*(n+1) peripheral clocks. P is PRE_HI when control bit 5 is 1 and PRE_LO when it is 0, and n is control bits [4:0].
- R3: Control bit 6 is the clock polarity. Whenever no frame is running, spi_sck equals that bit.
- R4: A frame is exactly 8 SCK pulses and is full duplex, MSB first. With control bit 7 (phase) at 0, MISO is sampled on the leading SCK edge and MOSI changes on the trailing edge. With bit 7 at 1, MOSI changes on the leading edge and MISO is sampled on the trailing edge.
- R5: A write to the transmit register (0x0C) while idle starts a frame, and only such a write starts one. Status bit 0 reads 1 from that write until the frame ends. A transmit write while bit 0 is 1 is ignored.
- R6: When a frame ends, the received byte appears in receive register bits [7:0] and status bit 2 becomes 1. Reading the receive register clears bit 2. A frame that completes while bit 2 is still 1 overwrites the held byte.
- R7: A write to the status register with data bit 2 equal to 0 clears status bit 2. With data bit 2 equal to 1, the write leaves it unchanged.
- R8: spi_cs_n follows system register bit 6 (1 = high/deasserted, 0 = low/asserted) and changes only on a write to 0x08. System register bits [7:0] read back as written.
- R9: A control register write while status bit 0 is 1 is ignored.
- R10: Read data appears on reg_rdata in the cycle after the read strobe and is 0 in all other cycles. The transmit register and every offset other than 0x00, 0x04, 0x08 and 0x10 read 0. Writes to unmapped offsets, including 0x14 and unaligned ones, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | One-cycle access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read, qualified by reg_sel |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, one cycle after the strobe |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, driven from system register bit 6 |

## Verification
The bound checker watches properties that hold on every cycle:
- the control register holds while a frame runs;
- frames start only from a transmit write;
- the receive flag rises only in the cycle a frame ends;
- the chip-select pin moves only on a system register write;
- unmapped reads return zero.

Other behaviour needs the bench's scenarios:
- the half-period length for all 64 divider codes;
- bit order and sampling edge in all four clock modes, checked against a slave model;
- overrun replacement;
- flag clearing by read and by status write;
- proof that a transmit written while busy never reaches the wire.

// File: rtl/spim_pkg.sv
package spim_pkg;
    // Register byte offsets: software depends on them, so they are fixed.
    localparam int OFF_CTRL = 'h00;
    localparam int OFF_STAT = 'h04;
    localparam int OFF_SYS  = 'h08;
    localparam int OFF_TX   = 'h0C;
    localparam int OFF_RX   = 'h10;

    // Control register fields
    localparam int CTL_HIPRE = 5;
    localparam int CTL_CPOL  = 6;
    localparam int CTL_CPHA  = 7;

    // Status register fields
    localparam int ST_BUSY = 0;
    localparam int ST_RXF  = 2;

    // System register: chip-select level bit
    localparam int SYS_CS  = 6;
    localparam logic [7:0] SYS_RESET = 8'h40;
endpackage

// File: rtl/spim_clkdiv.sv
module spim_clkdiv #(
    parameter int PRE_LO = 16,
    parameter int PRE_HI = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [5:0] div_sel,
    output logic       tick
);
    localparam int HALF_MAX = PRE_HI * 32;
    localparam int CNT_W    = $clog2(HALF_MAX + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] half_len;

    always_comb begin
        half_len = (div_sel[5] ? CNT_W'(PRE_HI) : CNT_W'(PRE_LO))
                 * (CNT_W'(div_sel[4:0]) + CNT_W'(1));
        tick  = run && (cnt_q == half_len - CNT_W'(1));
        cnt_d = cnt_q;
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] tx_byte,
    input  logic               cpol,
    input  logic               cpha,
    input  logic               tick,
    input  logic               miso,
    output logic               sck,
    output logic               mosi,
    output logic               busy,
    output logic               done,
    output logic [FRAME_W-1:0] rx_byte
);
    localparam int EDGES  = 2 * FRAME_W;
    localparam int EDGE_W = $clog2(EDGES);

    typedef struct packed {
        logic               busy;
        logic [EDGE_W-1:0]  ecnt;
        logic               sck;
        logic [FRAME_W-1:0] tx_sh;
        logic [FRAME_W-1:0] rx_sh;
    } shift_t;

    shift_t s_d, s_q;
    logic   odd;

    always_comb begin
        s_d  = s_q;
        done = 1'b0;
        odd  = s_q.ecnt[0];
        if (!s_q.busy) begin
            s_d.sck = cpol;
            if (start) begin
                s_d.busy  = 1'b1;
                s_d.ecnt  = '0;
                s_d.tx_sh = tx_byte;
                s_d.rx_sh = '0;
            end
        end else if (tick) begin
            s_d.sck = ~s_q.sck;
            // phase 0 samples on even (leading) edges, phase 1 on odd (trailing)
            if (cpha == odd)
                s_d.rx_sh = {s_q.rx_sh[FRAME_W-2:0], miso};
            if (cpha ? (!odd && (s_q.ecnt != '0)) : odd)
                s_d.tx_sh = {s_q.tx_sh[FRAME_W-2:0], 1'b0};
            if (s_q.ecnt == EDGE_W'(EDGES - 1)) begin
                s_d.busy = 1'b0;
                done     = 1'b1;
            end else begin
                s_d.ecnt = s_q.ecnt + EDGE_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sck     = s_q.busy ? s_q.sck : cpol;
    assign mosi    = s_q.tx_sh[FRAME_W-1];
    assign busy    = s_q.busy;
    assign rx_byte = s_d.rx_sh;
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
    import spim_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 32,
    parameter int FRAME_W = 8,
    parameter int PRE_LO  = 16,
    parameter int PRE_HI  = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_cs_n
);
    typedef struct packed {
        logic [7:0]         ctrl;
        logic [7:0]         sys;
        logic [FRAME_W-1:0] rx;
        logic               rxfull;
        logic [DATA_W-1:0]  rdata;
    } regs_t;

    regs_t              r_d, r_q;
    logic               busy, done, start, tick;
    logic [FRAME_W-1:0] rx_byte;
    logic               wr_hit, rd_hit;
    logic [7:0]         ctrl_w;
    logic               rxfull_w;
    logic               wdata_unused;

    assign wdata_unused = ^reg_wdata;

    always_comb begin
        r_d    = r_q;
        wr_hit = reg_sel && reg_wr;
        rd_hit = reg_sel && !reg_wr;
        start  = 1'b0;
        r_d.rdata = '0;
        if (wr_hit) begin
            if (reg_addr == ADDR_W'(OFF_CTRL) && !busy) r_d.ctrl = reg_wdata[7:0];
            if (reg_addr == ADDR_W'(OFF_STAT) && !reg_wdata[ST_RXF]) r_d.rxfull = 1'b0;
            if (reg_addr == ADDR_W'(OFF_SYS)) r_d.sys = reg_wdata[7:0];
            if (reg_addr == ADDR_W'(OFF_TX) && !busy) start = 1'b1;
        end
        if (rd_hit) begin
            case (reg_addr)
                ADDR_W'(OFF_CTRL): r_d.rdata = DATA_W'(r_q.ctrl);
                ADDR_W'(OFF_STAT): begin
                    r_d.rdata[ST_BUSY] = busy;
                    r_d.rdata[ST_RXF]  = r_q.rxfull;
                end
                ADDR_W'(OFF_SYS):  r_d.rdata = DATA_W'(r_q.sys);
                ADDR_W'(OFF_RX): begin
                    r_d.rdata  = DATA_W'(r_q.rx);
                    r_d.rxfull = 1'b0;
                end
                default:           r_d.rdata = '0;
            endcase
        end
        // a completing frame wins over a same-cycle clear
        if (done) begin
            r_d.rx     = rx_byte;
            r_d.rxfull = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.sys    <= SYS_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    spim_clkdiv #(.PRE_LO(PRE_LO), .PRE_HI(PRE_HI)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy),
        .div_sel (r_q.ctrl[5:0]),
        .tick    (tick)
    );

    spim_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .tx_byte (reg_wdata[FRAME_W-1:0]),
        .cpol    (r_q.ctrl[CTL_CPOL]),
        .cpha    (r_q.ctrl[CTL_CPHA]),
        .tick    (tick),
        .miso    (spi_miso),
        .sck     (spi_sck),
        .mosi    (spi_mosi),
        .busy    (busy),
        .done    (done),
        .rx_byte (rx_byte)
    );

    assign reg_rdata = r_q.rdata;
    assign spi_cs_n  = r_q.sys[SYS_CS];
    assign ctrl_w    = r_q.ctrl;
    assign rxfull_w  = r_q.rxfull;
endmodule

// File: rtl/spim_checker.sv
module spim_checker
    import spim_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_sel,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              busy,
    input logic [7:0]        ctrl,
    input logic              rxfull,
    input logic              cs_n
);
    logic mapped;
    assign mapped = (reg_addr == ADDR_W'(OFF_CTRL)) || (reg_addr == ADDR_W'(OFF_STAT)) ||
                    (reg_addr == ADDR_W'(OFF_SYS))  || (reg_addr == ADDR_W'(OFF_RX));

    assert_ctrl_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ctrl));

    assert_start_from_tx_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(reg_sel && reg_wr && reg_addr == ADDR_W'(OFF_TX)));

    assert_flag_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rxfull) |-> $fell(busy));

    assert_cs_only_by_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_sel && reg_wr && reg_addr == ADDR_W'(OFF_SYS)) |=> $stable(cs_n));

    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && !reg_wr && !mapped) |=> (reg_rdata == '0));
endmodule

bind spi_byte_master spim_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_sel   (reg_sel),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .busy      (busy),
    .ctrl      (ctrl_w),
    .rxfull    (rxfull_w),
    .cs_n      (spi_cs_n)
);

// File: tb/test_spi_byte_master.sv
module test_spi_byte_master;
    localparam int PRE_LO = 2;
    localparam int PRE_HI = 4;
    localparam int A_CTRL = 'h00, A_STAT = 'h04, A_SYS = 'h08, A_TX = 'h0C, A_RX = 'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0, reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        spi_sck, spi_mosi, spi_miso, spi_cs_n;

    always #2.5 clk = ~clk;

    spi_byte_master #(.PRE_LO(PRE_LO), .PRE_HI(PRE_HI)) i_spi_byte_master (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    int n_chk = 0, n_fail = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input int addr, input int data);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = 5'(addr); reg_wdata = 32'(data);
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic reg_read(input int addr, output int data);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = 5'(addr);
        @(negedge clk);
        reg_sel = 1'b0;
        data = int'(reg_rdata);
    endtask

    // slave model
    logic [7:0] s_tx = '0, s_rx = '0;
    int         s_idx = 0, s_lead = 0, s_trail = 0;
    logic       s_cpol = 1'b0, s_cpha = 1'b0;

    assign spi_miso = (s_idx < 8) ? s_tx[3'(7 - s_idx)] : 1'b0;

    always @(spi_sck) begin
        if (rst_n && spi_cs_n === 1'b0) begin
            if (spi_sck != s_cpol) begin
                if (!s_cpha) s_rx = {s_rx[6:0], spi_mosi};
                else         s_idx = s_lead;
                s_lead++;
            end else begin
                if (s_cpha)  s_rx = {s_rx[6:0], spi_mosi};
                else         s_idx = s_trail + 1;
                s_trail++;
            end
        end
    end

    task automatic wait_idle();
        int st;
        for (int i = 0; i < 5000; i++) begin
            reg_read(A_STAT, st);
            if (st[0] == 1'b0) break;
        end
    endtask

    task automatic set_mode(input int ctrl);
        reg_write(A_SYS, 'h61);
        reg_write(A_CTRL, ctrl);
        s_cpol = ctrl[6];
        s_cpha = ctrl[7];
        reg_write(A_SYS, 'h21);
    endtask

    task automatic xfer(input logic [7:0] tx, input logic [7:0] stx);
        s_tx = stx; s_idx = 0; s_lead = 0; s_trail = 0; s_rx = '0;
        reg_write(A_TX, int'(tx));
        wait_idle();
    endtask

    initial begin
        #(5.0 * 190000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int v, st;
        logic prev;
        int c;
        logic [7:0] pats [5] = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h81};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(spi_cs_n == 1'b1, "R1", "cs_n", int'(spi_cs_n), 1);
        check(spi_sck == 1'b0, "R1", "sck", int'(spi_sck), 0);
        check(spi_mosi == 1'b0, "R1", "mosi", int'(spi_mosi), 0);
        reg_read(A_CTRL, v); check(v == 0, "R1", "ctrl", v, 0);
        reg_read(A_STAT, v); check(v == 0, "R1", "status", v, 0);
        reg_read(A_RX, v);   check(v == 0, "R1", "rx", v, 0);
        reg_read(A_SYS, v);  check(v == 'h40, "R1", "sys", v, 'h40);

        // R10 bus latency and unmapped offsets
        @(negedge clk);
        check(reg_rdata == 0, "R10", "rdata idle", int'(reg_rdata), 0);
        reg_write('h14, 'hFF);
        reg_write('h18, 'hFF);
        reg_write('h01, 'hFF);
        reg_read(A_CTRL, v); check(v == 0, "R10", "ctrl after unmapped writes", v, 0);
        reg_read('h14, v);   check(v == 0, "R10", "read 0x14", v, 0);
        reg_read('h18, v);   check(v == 0, "R10", "read 0x18", v, 0);
        reg_read(A_TX, v);   check(v == 0, "R10", "read tx", v, 0);

        // R8 chip select
        reg_write(A_SYS, 'h21);
        @(negedge clk);
        check(spi_cs_n == 1'b0, "R8", "cs_n low", int'(spi_cs_n), 0);
        reg_read(A_SYS, v); check(v == 'h21, "R8", "sys readback", v, 'h21);
        reg_write(A_SYS, 'h61);
        @(negedge clk);
        check(spi_cs_n == 1'b1, "R8", "cs_n high", int'(spi_cs_n), 1);

        // R2 divider sweep over all 64 codes, chip select high
        for (int sel = 0; sel < 64; sel++) begin
            int exp_h;
            exp_h = ((sel & 32) != 0 ? PRE_HI : PRE_LO) * ((sel & 31) + 1);
            reg_write(A_CTRL, sel);
            reg_write(A_TX, 0);
            prev = spi_sck;
            c = 0;
            while (spi_sck == prev && c < 1000) begin @(negedge clk); c++; end
            prev = spi_sck; c = 0;
            do begin @(negedge clk); c++; end while (spi_sck == prev && c < 1000);
            check(c == exp_h, "R2", $sformatf("half period code %0d", sel), c, exp_h);
            wait_idle();
        end

        // R4 / R6 / R3 all four modes
        for (int m = 0; m < 4; m++) begin
            set_mode(m << 6);
            for (int p = 0; p < 5; p++) begin
                logic [7:0] stx;
                stx = {pats[p][3:0], pats[p][7:4]} ^ 8'h96;
                xfer(pats[p], stx);
                check(s_rx == pats[p], "R4", $sformatf("slave got, mode %0d", m), int'(s_rx), int'(pats[p]));
                check(s_lead == 8, "R4", "sck pulses", s_lead, 8);
                reg_read(A_STAT, st);
                check(st == 4, "R6", "status after frame", st, 4);
                reg_read(A_RX, v);
                check(v == int'(stx), "R4", $sformatf("master got, mode %0d", m), v, int'(stx));
                reg_read(A_STAT, st);
                check(st == 0, "R6", "flag cleared by rx read", st, 0);
                check(spi_sck == m[0], "R3", "idle sck level", int'(spi_sck), m[0]);
            end
        end

        // R5 / R9 writes while busy
        set_mode('h01);
        s_tx = 8'h00; s_idx = 0; s_lead = 0; s_trail = 0; s_rx = '0;
        reg_write(A_TX, 'h3C);
        reg_read(A_STAT, st);
        check(st[0] == 1'b1, "R5", "busy bit during frame", st, 1);
        reg_write(A_TX, 'hC3);
        reg_write(A_CTRL, 'hC0);
        wait_idle();
        repeat (200) @(negedge clk);
        check(s_rx == 8'h3C, "R5", "only first byte sent", int'(s_rx), 'h3C);
        check(s_lead == 8, "R5", "single frame pulses", s_lead, 8);
        reg_read(A_STAT, st);
        check(st == 4, "R5", "idle after one frame", st, 4);
        reg_read(A_CTRL, v);
        check(v == 1, "R9", "ctrl write while busy", v, 1);
        reg_read(A_RX, v);

        // R6 overrun
        set_mode(0);
        xfer(8'h11, 8'hA1);
        xfer(8'h22, 8'hB2);
        reg_read(A_RX, v);
        check(v == 'hB2, "R6", "overrun keeps newest", v, 'hB2);

        // R7 status writes
        xfer(8'h33, 8'hC3);
        reg_write(A_STAT, 4);
        reg_read(A_STAT, st);
        check(st == 4, "R7", "status write bit2=1 keeps flag", st, 4);
        reg_write(A_STAT, 0);
        reg_read(A_STAT, st);
        check(st == 0, "R7", "status write 0 clears", st, 0);
        reg_read(A_RX, v);
        check(v == 'hC3, "R7", "rx byte kept after clear", v, 'hC3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule